// File: doc/BRIEF.md
# Way-Predicted Two-Way Instruction Cache Lookup

This block is the lookup engine of a two-way set-associative instruction cache. Every set has a one-bit guess of which way will serve the next fetch to it. A fetch reads only the guessed way first. If that way's tag matches, the word is returned on the next cycle, just as fast as a direct-mapped cache. If it does not match, the other way of the same set is probed one cycle later. A hit there takes three cycles in total and moves the guess to that way. If neither way holds the line, a miss request is raised toward a memory model and the block stalls until that model supplies the word.

The tag, valid and data arrays are internal registers, and each line holds one data word. Fetches enter through a valid/ready request channel and leave through a valid/ready response channel. A request is accepted only when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` stays low from that edge until the response has been taken, so only one fetch is ever in flight. A response holds all of its fields stable while `rsp_ready` is low, and it is consumed on the edge where `rsp_valid` and `rsp_ready` are both high. The miss handshake uses plain level signals. `miss_req` stays high until a cycle with `refill_valid` high, and that cycle delivers the word.

Top module: `wp_icache_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `miss_req` is 0. Every line is invalid and every set's guess points at way 0, so the first fetch to any address misses.
- R2: If the guessed way holds a valid line with a matching tag, the response appears in the cycle right after the accept cycle, with `rsp_hit`=1 and `rsp_lat`=2'b01 (fast).
- R3: If the guessed way does not match but the other way does, the response appears three cycles after the accept cycle, with `rsp_hit`=1, `rsp_lat`=2'b10 (slow) and that way's word.
- R4: A slow hit moves the set's guess to the way that hit, so the next fetch of the same line is a fast hit.
- R5: If neither way matches, `miss_req` rises two cycles after the accept cycle, with `miss_addr` equal to `req_addr[ADDR_W-1:2]`. Both stay unchanged until a cycle with `refill_valid` high.
- R6: A refill writes the line into an invalid way: way 0 if both are invalid, otherwise the one that is invalid. If both ways are valid, it writes the way the guess does not point at. In every case the guess then points at the refilled way.
- R7: The cycle after the refill cycle presents a response with `rsp_data`=`refill_data`, `rsp_hit`=0 and `rsp_lat`=2'b11 (miss).
- R8: `req_ready` is 0 from the accept edge until the response is taken. A `refill_valid` pulse while no miss is pending has no effect on the arrays.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_data`, `rsp_hit` and `rsp_lat` hold their values.
- R10: Each set has its own guess bit; the index is `req_addr[2 +: log2(SETS)]` and the tag is the bits above it. Fetches to one set do not change the guess or the lines of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can accept a fetch |
| req_addr | input | ADDR_W | Byte address of the fetch |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Fetched word |
| rsp_hit | output | 1 | 1 on a fast or slow hit, 0 on a miss |
| rsp_lat | output | 2 | Latency class: 01 fast, 10 slow, 11 miss |
| miss_req | output | 1 | Line missing, waiting for refill |
| miss_addr | output | ADDR_W-2 | Line address of the missing word |
| refill_valid | input | 1 | Refill word delivered this cycle |
| refill_data | input | DATA_W | Refill word |

## Verification
The bench drives three tags into one set, which forces every ordering of guess and contents. A design that probed both ways at once would report a slow hit as fast, or in the wrong cycle. A design that forgot to move the guess would keep returning slow hits for a line it had just found in the other way. A design that picked the wrong victim, for example by evicting the guessed line or overwriting a valid way while the other was empty, is caught by the next fetch of the line that should have survived: that fetch misses. The bench also sends a stray refill pulse while no miss is pending, holds back a response with `rsp_ready`, and uses a second set to show that the guess bits of different sets are independent.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam logic [1:0] LAT_NONE = 2'b00;
  localparam logic [1:0] LAT_FAST = 2'b01;
  localparam logic [1:0] LAT_SLOW = 2'b10;
  localparam logic [1:0] LAT_MISS = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ALT  = 3'd1,
    ST_SLOW = 3'd2,
    ST_MISS = 3'd3,
    ST_RESP = 3'd4
  } lookup_state_e;
endpackage

// File: rtl/wpc_way_store.sv
module wpc_way_store #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 11,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   line_ok;
  logic [TAG_W-1:0]  tag_mem [SETS];
  logic [DATA_W-1:0] word_mem[SETS];

  // valid bits are the only state that needs a reset value
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_ok <= '0;
    end else if (wr_en) begin
      line_ok[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      word_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = line_ok[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = word_mem[rd_idx];

  // R6: a filled line becomes valid
  a_r6_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> line_ok[$past(wr_idx)]);
endmodule

// File: rtl/wpc_pred_table.sv
module wpc_pred_table #(
  parameter int SETS = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             guess_way,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_way
);
  logic [SETS-1:0] guess_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      guess_bits <= '0;
    end else if (upd_en) begin
      guess_bits[upd_idx] <= upd_way;
    end
  end

  assign guess_way = guess_bits[rd_idx];

  // R4: an update lands in the addressed set
  a_r4_guess_written: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> guess_bits[$past(upd_idx)] == $past(upd_way));
endmodule

// File: rtl/wp_icache_lookup.sv
module wp_icache_lookup
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  localparam int OFF_W  = $clog2(DATA_W / 8),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic [1:0]        rsp_lat,
  output logic              miss_req,
  output logic [LINE_W-1:0] miss_addr,
  input  logic              refill_valid,
  input  logic [DATA_W-1:0] refill_data
);
  lookup_state_e state_q;
  logic [LINE_W-1:0] line_q;
  logic              alt_q;
  logic [DATA_W-1:0] data_q;
  logic              hit_q;
  logic [1:0]        lat_q;

  logic              unused_offset;
  logic [IDX_W-1:0]  req_idx, cur_idx, rd_idx;
  logic [TAG_W-1:0]  req_tag, cur_tag, probe_tag;
  logic              guess_way, probe_way, probe_hit, victim;
  logic              accept, refill_take, upd_en, upd_way;
  logic [1:0]        way_vld, fill_we;
  logic [TAG_W-1:0]  way_tag[2];
  logic [DATA_W-1:0] way_dat[2];

  assign unused_offset = ^req_addr[OFF_W-1:0];
  assign req_idx = req_addr[OFF_W +: IDX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign cur_idx = line_q[IDX_W-1:0];
  assign cur_tag = line_q[LINE_W-1 -: TAG_W];

  // while idle the arrays are read at the incoming address, otherwise at the held one
  assign rd_idx    = (state_q == ST_IDLE) ? req_idx : cur_idx;
  assign probe_tag = (state_q == ST_IDLE) ? req_tag : cur_tag;
  assign probe_way = (state_q == ST_IDLE) ? guess_way : alt_q;
  assign probe_hit = way_vld[probe_way] && (way_tag[probe_way] == probe_tag);

  assign accept      = req_valid && (state_q == ST_IDLE);
  assign refill_take = refill_valid && (state_q == ST_MISS);

  // victim: an empty way first, else the way the guess does not name
  always_comb begin
    if (!way_vld[0])      victim = 1'b0;
    else if (!way_vld[1]) victim = 1'b1;
    else                  victim = ~guess_way;
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_way
      assign fill_we[g] = refill_take && (victim == 1'(g));
      wpc_way_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_valid(way_vld[g]),
        .rd_tag  (way_tag[g]),
        .rd_data (way_dat[g]),
        .wr_en   (fill_we[g]),
        .wr_idx  (cur_idx),
        .wr_tag  (cur_tag),
        .wr_data (refill_data)
      );
    end
  endgenerate

  assign upd_en  = ((state_q == ST_ALT) && probe_hit) || refill_take;
  assign upd_way = (state_q == ST_ALT) ? alt_q : victim;

  wpc_pred_table #(.SETS(SETS)) i_pred (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .guess_way(guess_way),
    .upd_en   (upd_en),
    .upd_idx  (cur_idx),
    .upd_way  (upd_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      alt_q   <= 1'b0;
      data_q  <= '0;
      hit_q   <= 1'b0;
      lat_q   <= LAT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          line_q <= req_addr[ADDR_W-1:OFF_W];
          alt_q  <= ~guess_way;
          if (probe_hit) begin
            data_q  <= way_dat[probe_way];
            hit_q   <= 1'b1;
            lat_q   <= LAT_FAST;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_ALT;
          end
        end
        ST_ALT: begin
          if (probe_hit) begin
            data_q  <= way_dat[probe_way];
            state_q <= ST_SLOW;
          end else begin
            state_q <= ST_MISS;
          end
        end
        ST_SLOW: begin
          hit_q   <= 1'b1;
          lat_q   <= LAT_SLOW;
          state_q <= ST_RESP;
        end
        ST_MISS: if (refill_take) begin
          data_q  <= refill_data;
          hit_q   <= 1'b0;
          lat_q   <= LAT_MISS;
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_data  = data_q;
  assign rsp_hit   = hit_q;
  assign rsp_lat   = lat_q;
  assign miss_req  = (state_q == ST_MISS);
  assign miss_addr = line_q;

  // R2: a guessed-way match answers on the next cycle
  a_r2_fast_path: assert property (@(posedge clk) disable iff (!rst_n)
    accept && probe_hit |=> rsp_valid && rsp_lat == LAT_FAST && rsp_hit);

  // R8: no second fetch while one is in flight
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R5: miss request and address hold until the refill arrives
  a_r5_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req && !refill_valid |=> miss_req && $stable(miss_addr));

  // R7: refill word is returned as a miss response
  a_r7_refill_resp: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req && refill_valid |=> rsp_valid && rsp_lat == LAT_MISS && !rsp_hit
      && rsp_data == $past(refill_data));

  // R9: a stalled response does not change
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit)
      && $stable(rsp_lat));

  // R3: slow responses always come from the second probe
  a_r3_slow_after_alt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_lat == LAT_SLOW |-> $past(state_q, 2) == ST_ALT);
endmodule

// File: tb/test_wp_icache_lookup.sv
module test_wp_icache_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LINE_W = ADDR_W - 2;
  localparam logic [1:0] C_FAST = 2'b01;
  localparam logic [1:0] C_SLOW = 2'b10;
  localparam logic [1:0] C_MISS = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [DATA_W-1:0] rsp_data;
  logic rsp_hit;
  logic [1:0] rsp_lat;
  logic miss_req;
  logic [LINE_W-1:0] miss_addr;
  logic refill_valid = 1'b0;
  logic [DATA_W-1:0] refill_data = '0;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wp_icache_lookup i_wp_icache_lookup (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_hit(rsp_hit), .rsp_lat(rsp_lat),
    .miss_req(miss_req), .miss_addr(miss_addr),
    .refill_valid(refill_valid), .refill_data(refill_data)
  );

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {16'hA55A ^ {a[15:2], 2'b00}, a[15:2], 2'b00};
  endfunction

  task automatic check_eq(input string req, input logic [DATA_W-1:0] act,
                          input logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one fetch; a pending miss is served after two idle cycles; hold>0 stalls the response
  task automatic fetch(input logic [ADDR_W-1:0] a, input logic [1:0] exp_lat,
                       input string req, input int hold);
    int cycles;
    bit refilled;
    refilled = 1'b0;
    @(negedge clk);
    check_eq({req, " R8 ready before fetch"}, req_ready, 1);
    rsp_ready = (hold == 0);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 1;
    while (!rsp_valid && cycles < 40) begin
      if (miss_req && !refilled) begin
        check_eq({req, " R5 miss rises two cycles after accept"}, cycles, 2);
        check_eq({req, " R5 miss address"}, miss_addr, a[15:2]);
        repeat (2) @(negedge clk);
        cycles += 2;
        check_eq({req, " R5 miss held"}, {miss_req, miss_addr}, {1'b1, a[15:2]});
        refill_valid = 1'b1;
        refill_data  = mem_word(a);
        refilled = 1'b1;
      end
      check_eq({req, " R8 busy while in flight"}, req_ready, 0);
      @(negedge clk);
      refill_valid = 1'b0;
      cycles++;
    end
    check_eq({req, " response present"}, rsp_valid, 1);
    check_eq({req, " latency class"}, rsp_lat, exp_lat);
    check_eq({req, " hit flag"}, rsp_hit, (exp_lat != C_MISS));
    check_eq({req, " data"}, rsp_data, mem_word(a));
    if (exp_lat == C_FAST) check_eq({req, " fast cycles"}, cycles, 1);
    if (exp_lat == C_SLOW) check_eq({req, " slow cycles"}, cycles, 3);
    if (hold > 0) begin
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        check_eq({req, " R9 held response"}, {rsp_valid, rsp_lat, rsp_data},
                 {1'b1, exp_lat, mem_word(a)});
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      check_eq({req, " R9 released"}, rsp_valid, 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_eq("R1 ready after reset", req_ready, 1);
    check_eq("R1 no response after reset", rsp_valid, 0);
    check_eq("R1 no miss after reset", miss_req, 0);
  endtask

  // set 0 with tags 1, 2, 3
  task automatic t_one_set;
    fetch(16'h0020, C_MISS, "R1 cold miss", 0);
    fetch(16'h0020, C_FAST, "R2 fast hit", 0);
    fetch(16'h0040, C_MISS, "R6 fill empty way1", 0);
    fetch(16'h0040, C_FAST, "R6 guess at refilled way", 0);
    fetch(16'h0020, C_SLOW, "R3 slow hit", 0);
    fetch(16'h0020, C_FAST, "R4 guess moved", 0);
    fetch(16'h0060, C_MISS, "R7 miss both valid", 0);
    fetch(16'h0020, C_SLOW, "R6 guessed line kept", 0);
    fetch(16'h0040, C_MISS, "R6 unguessed line evicted", 0);
  endtask

  task automatic t_other_set;
    fetch(16'h0024, C_MISS, "R10 other set cold", 0);
    fetch(16'h0024, C_FAST, "R10 other set fast", 0);
    fetch(16'h0040, C_FAST, "R10 set0 guess untouched", 0);
  endtask

  task automatic t_backpressure;
    fetch(16'h0024, C_FAST, "R9 stalled fast hit", 3);
  endtask

  task automatic t_stray_refill;
    @(negedge clk);
    refill_valid = 1'b1;
    refill_data  = 32'hDEAD_BEEF;
    @(negedge clk);
    refill_valid = 1'b0;
    check_eq("R8 stray refill gives no response", rsp_valid, 0);
    fetch(16'h0024, C_FAST, "R8 line intact after stray refill", 0);
    fetch(16'h00A8, C_MISS, "R8 stray refill installed nothing", 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_one_set();
    t_other_set();
    t_backpressure();
    t_stray_refill();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule